// File: doc/BRIEF.md
# Clear-on-Read Interrupt Controller

This block keeps one sticky flag per interrupt source and drives a single active-low interrupt line towards a host. A one-cycle event pulse on any source input raises its flag, whatever the enable mask holds. The line goes low while at least one raised flag also has its enable bit set. The serial register interface that sits beside this block reports each read with two strobes: a start strobe that carries the register address, and a done strobe at the end of the data transfer.

The flags can be read in two ways. A plain read at the status address returns them and leaves them as they are. A read at the clearing address (0x0C) takes a snapshot of the flags at the start strobe and returns it. While that transfer runs, the interrupt line is held high. New events are parked in a pending register. At the done strobe, the flags that were returned are cleared and the parked events are merged in. If any of those merged events is enabled, the line drops again. No event is lost, however close it falls to either strobe.

Top module: `irqc_top`

## Requirements
- R1: A synchronous active-high reset clears all flags, the pending register and the enable mask, sets `rd_data` to 0, and drives `irq_n` high.
- R2: When the controller is idle, an event pulse on bit i of `evt_i` sets flag i at the next clock edge, whatever enable bit i holds.
- R3: Outside a clearing transfer, `irq_n` is registered and updated at the same edge as the flags and the mask. It is 0 exactly when some flag i and enable bit i are both 1.
- R4: A pulse on `en_we` loads `en_wdata` into the enable mask at that edge. With existing flags, this can assert or deassert `irq_n` in the same cycle.
- R5: A start strobe with `rd_addr` equal to the status address (0x0B) loads the current flags into `rd_data` at that edge. It changes neither the flags nor `irq_n`.
- R6: A start strobe with `rd_addr` equal to the clearing address (0x0C) loads the current flags into `rd_data` as a snapshot and begins a transfer. At the done strobe that ends the transfer, exactly the snapshot bits are cleared.
- R7: `irq_n` is 1 from the edge that starts a clearing transfer up to the edge of its done strobe.
- R8: Events that arrive while a clearing transfer runs, including in the cycle of its start strobe, are held. They become flags at the done strobe, and `irq_n` then falls if any of them is enabled.
- R9: The following strobes are ignored and change neither `rd_data` nor the flags nor `irq_n`: a done strobe when no transfer runs, a start strobe while a transfer runs, and a start strobe at any other address.
- R10: An event that arrives in the same cycle as the done strobe ends up as a flag after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 16 | One-cycle event pulses, one per source |
| en_we | input | 1 | Enable mask write strobe |
| en_wdata | input | 16 | New enable mask value |
| rd_start | input | 1 | Read start strobe from the serial interface |
| rd_addr | input | 6 | Register address of the read |
| rd_done | input | 1 | End of read data transfer strobe |
| rd_data | output | 16 | Registered read value (flags or snapshot) |
| irq_n | output | 1 | Interrupt line, active low |

## Verification
Two kinds of activity can land in the same clock cycle: an event pulse and a read strobe. An event that coincides with the start strobe of a clearing read must go to the pending register, not into the snapshot. An event that coincides with the done strobe must survive the clear. The bench provokes both coincidences with directed steps. It then lets random events overlap random plain and clearing reads and enable writes for thousands of cycles. Every cycle it compares `irq_n` and `rd_data` with a cycle model built from the requirements. The flags that survive are judged through later plain reads.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_PLAIN = 2'd1,
    RD_CLEAR = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/irqc_rd_decode.sv
module irqc_rd_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 6'h0B,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 6'h0C
) (
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              busy,
  output rd_kind_e          kind
);
  always_comb begin
    kind = RD_NONE;
    if (rd_start && !busy) begin
      if (rd_addr == CLR_ADDR)       kind = RD_CLEAR;
      else if (rd_addr == STAT_ADDR) kind = RD_PLAIN;
    end
  end
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags
  import irqc_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt_i,
  input  rd_kind_e        kind,
  input  logic            rd_done,
  output logic [NSRC-1:0] status_q,
  output logic [NSRC-1:0] status_nx,
  output logic [NSRC-1:0] pend_q,
  output logic            busy_q,
  output logic            busy_nx
);
  logic [NSRC-1:0] snap_q;
  logic [NSRC-1:0] pend_nx;
  logic [NSRC-1:0] snap_nx;
  logic            start_clr;
  logic            finish;

  assign start_clr = (kind == RD_CLEAR);
  assign finish    = busy_q && rd_done;

  always_comb begin
    busy_nx = busy_q;
    if (start_clr)   busy_nx = 1'b1;
    else if (finish) busy_nx = 1'b0;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_comb begin
      status_nx[i] = status_q[i];
      pend_nx[i]   = pend_q[i];
      snap_nx[i]   = snap_q[i];
      if (start_clr) begin
        snap_nx[i] = status_q[i];
        pend_nx[i] = evt_i[i];
      end else if (finish) begin
        status_nx[i] = (status_q[i] & ~snap_q[i]) | pend_q[i] | evt_i[i];
        pend_nx[i]   = 1'b0;
        snap_nx[i]   = 1'b0;
      end else if (busy_q) begin
        pend_nx[i] = pend_q[i] | evt_i[i];
      end else begin
        status_nx[i] = status_q[i] | evt_i[i];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        status_q[i] <= 1'b0;
        pend_q[i]   <= 1'b0;
        snap_q[i]   <= 1'b0;
      end else begin
        status_q[i] <= status_nx[i];
        pend_q[i]   <= pend_nx[i];
        snap_q[i]   <= snap_nx[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= busy_nx;
  end
endmodule

// File: rtl/irqc_drive.sv
module irqc_drive #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_wdata,
  input  logic [NSRC-1:0] status_nx,
  input  logic            busy_nx,
  output logic [NSRC-1:0] en_q,
  output logic            irq_n
);
  logic [NSRC-1:0] en_nx;
  logic            fire_nx;

  assign en_nx   = en_we ? en_wdata : en_q;
  assign fire_nx = (|(status_nx & en_nx)) && !busy_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq_n <= 1'b1;
    end else begin
      en_q  <= en_nx;
      irq_n <= ~fire_nx;
    end
  end
endmodule

// File: rtl/irqc_rdport.sv
module irqc_rdport
  import irqc_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  rd_kind_e        kind,
  input  logic [NSRC-1:0] status_q,
  output logic [NSRC-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst)                  rd_data <= '0;
    else if (kind != RD_NONE) rd_data <= status_q;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 6'h0B,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 6'h0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              en_we,
  input  logic [NSRC-1:0]   en_wdata,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_done,
  output logic [NSRC-1:0]   rd_data,
  output logic              irq_n
);
  rd_kind_e        kind;
  logic [NSRC-1:0] status_q, status_nx, pend_q, en_q;
  logic            busy_q, busy_nx;

  irqc_rd_decode #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CLR_ADDR(CLR_ADDR)) u_dec (
    .rd_start(rd_start), .rd_addr(rd_addr), .busy(busy_q), .kind(kind)
  );

  irqc_flags #(.NSRC(NSRC)) u_flags (
    .clk(clk), .rst(rst), .evt_i(evt_i), .kind(kind), .rd_done(rd_done),
    .status_q(status_q), .status_nx(status_nx), .pend_q(pend_q),
    .busy_q(busy_q), .busy_nx(busy_nx)
  );

  irqc_drive #(.NSRC(NSRC)) u_drive (
    .clk(clk), .rst(rst), .en_we(en_we), .en_wdata(en_wdata),
    .status_nx(status_nx), .busy_nx(busy_nx), .en_q(en_q), .irq_n(irq_n)
  );

  irqc_rdport #(.NSRC(NSRC)) u_rdport (
    .clk(clk), .rst(rst), .kind(kind), .status_q(status_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int NSRC = 16,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 6'h0B
) (
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   evt_i,
  input logic              rd_start,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_done,
  input logic              irq_n,
  input logic              busy_q,
  input logic [NSRC-1:0]   status_q,
  input logic [NSRC-1:0]   pend_q,
  input logic [NSRC-1:0]   en_q
);
  // R7
  busy_irq_high_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> irq_n);

  // R2
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !(rd_start && rd_addr != STAT_ADDR) && |evt_i) |=>
      ((status_q & $past(evt_i)) == $past(evt_i)));

  // R8
  pend_merge_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && rd_done) |=>
      ((status_q & $past(pend_q | evt_i)) == $past(pend_q | evt_i)));

  // R5
  plain_read_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && rd_start && rd_addr == STAT_ADDR && evt_i == '0) |=>
      (status_q == $past(status_q)));

  // R9
  idle_done_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && rd_done && !rd_start) |=> !busy_q);

  // R3
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (irq_n == !(|(status_q & en_q))));
endmodule

bind irqc_top irqc_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .rd_start(rd_start), .rd_addr(rd_addr),
  .rd_done(rd_done), .irq_n(irq_n), .busy_q(busy_q), .status_q(status_q),
  .pend_q(pend_q), .en_q(en_q)
);

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_STAT = 6'h0B;
  localparam logic [5:0] A_CLR  = 6'h0C;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] evt_i;
  logic        en_we;
  logic [15:0] en_wdata;
  logic        rd_start;
  logic [5:0]  rd_addr;
  logic        rd_done;
  logic [15:0] rd_data;
  logic        irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  logic [15:0] m_st, m_pend, m_snap, m_en, m_rd;
  logic        m_busy, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top dut_i (
    .clk(clk), .rst(rst), .evt_i(evt_i), .en_we(en_we), .en_wdata(en_wdata),
    .rd_start(rd_start), .rd_addr(rd_addr), .rd_done(rd_done),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model(input logic [15:0] e, input logic w, input logic [15:0] wd,
                       input logic s, input logic [5:0] a, input logic d);
    logic clr_go, plain_go, fin;
    clr_go   = s && !m_busy && (a == A_CLR);
    plain_go = s && !m_busy && (a == A_STAT);
    fin      = d && m_busy;
    if (plain_go) m_rd = m_st;
    if (clr_go) begin
      m_rd = m_st; m_snap = m_st; m_pend = e; m_busy = 1'b1;
    end else if (fin) begin
      m_st = (m_st & ~m_snap) | m_pend | e; m_pend = '0; m_busy = 1'b0;
    end else if (m_busy) begin
      m_pend = m_pend | e;
    end else begin
      m_st = m_st | e;
    end
    if (w) m_en = wd;
    m_irq = m_busy ? 1'b1 : !(|(m_st & m_en));
  endtask

  // Called at a negative edge; applies inputs for one cycle and checks after the edge.
  task automatic step(input string tag, input logic [15:0] e, input logic w,
                      input logic [15:0] wd, input logic s, input logic [5:0] a,
                      input logic d);
    evt_i = e; en_we = w; en_wdata = wd; rd_start = s; rd_addr = a; rd_done = d;
    @(posedge clk);
    model(e, w, wd, s, a, d);
    @(negedge clk);
    evt_i = '0; en_we = 1'b0; rd_start = 1'b0; rd_done = 1'b0;
    check({tag, " irq_n"}, {15'd0, irq_n}, {15'd0, m_irq});
    check({tag, " rd_data"}, rd_data, m_rd);
  endtask

  task automatic idle(input string tag);
    step(tag, '0, 1'b0, '0, 1'b0, 6'h00, 1'b0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst = 1'b1; evt_i = '0; en_we = 0; en_wdata = '0; rd_start = 0; rd_addr = '0; rd_done = 0;
    m_st = '0; m_pend = '0; m_snap = '0; m_en = '0; m_rd = '0; m_busy = 0; m_irq = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 irq_n", {15'd0, irq_n}, 16'd1);
    check("R1 rd_data", rd_data, 16'h0000);
    rst = 1'b0;
    step("R1 read", '0, 0, '0, 1, A_STAT, 0);

    // R2: flag set with mask clear, line stays high
    step("R2", 16'h0008, 0, '0, 0, 6'h00, 0);
    step("R2 read", '0, 0, '0, 1, A_STAT, 0);
    // R4: mask write asserts then deasserts
    step("R4 on", '0, 1, 16'h0008, 0, 6'h00, 0);
    step("R4 off", '0, 1, 16'h0000, 0, 6'h00, 0);
    step("R4 mask", '0, 1, 16'h02F0, 0, 6'h00, 0);
    // R3: enabled event drops the line
    step("R3", 16'h0020, 0, '0, 0, 6'h00, 0);
    // R5: plain read leaves flags and line
    step("R5", '0, 0, '0, 1, A_STAT, 0);
    idle("R5 after");
    // R6 R7 R8: clearing read with event in the start cycle and during transfer
    step("R8 start", 16'h0001, 0, '0, 1, A_CLR, 0);
    step("R7 hold", 16'h0200, 0, '0, 0, 6'h00, 0);
    // R9: restart while busy is ignored
    step("R9 busy start", '0, 0, '0, 1, A_STAT, 0);
    idle("R7 hold2");
    step("R6 done", '0, 0, '0, 0, 6'h00, 1);
    step("R6 read", '0, 0, '0, 1, A_STAT, 0);
    // R9: idle done and unknown address are ignored
    step("R9 idle done", '0, 0, '0, 0, 6'h00, 1);
    step("R9 bad addr", 16'h0000, 0, '0, 1, 6'h01, 0);
    // R10: event on done cycle survives
    step("R10 start", '0, 0, '0, 1, A_CLR, 0);
    step("R10 done", 16'h0040, 0, '0, 0, 6'h00, 1);
    step("R10 read", '0, 0, '0, 1, A_STAT, 0);

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      logic [15:0] e, wd;
      logic w, s, d;
      logic [5:0] a;
      int r;
      e  = (($urandom % 4) == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
      w  = (($urandom % 16) == 0);
      wd = 16'($urandom);
      s  = (($urandom % 6) == 0);
      r  = $urandom % 5;
      a  = (r < 2) ? A_CLR : (r < 4) ? A_STAT : 6'($urandom);
      d  = (($urandom % 4) == 0);
      step("R3 R6 R8 random", e, w, wd, s, a, d);
    end
    finish_run();
  end
endmodule